// File: doc/BRIEF.md
# Serial Transmit Queue

This block is an asynchronous serial transmitter fed from a byte FIFO. The host writes bytes through a small register port, and the block shifts each byte out on a single line. The host uses two status flags to decide when to write more data. The first is a low-water flag that compares the queue level with a selectable threshold. The second is a transmission-done flag. The host can also read the FIFO level directly, so it knows how much free space remains.

The host clears each status flag in two steps. It must first read the flag as 1, and then write 0 to it. A transmit-enable bit gates the shifter. When transmit is disabled, a pair of override bits lets the host hold the line at a fixed level, for example low to send a break.

Register addresses: 0 data (write pushes a byte), 1 status, 2 control, 3 level, 4 divisor.

Top module: `serial_tx_queue`

## Requirements
- R1: After reset, status reads low-water=1 (bit 0), done=1 (bit 1) and overflow=0 (bit 2). The level register reads 0 and tx_o is high.
- R2: Each frame is a low start bit, then 8 data bits with the LSB first, then a high stop bit. Every bit lasts divisor+1 clock cycles, with the divisor at address 4.
- R3: Queued bytes are sent in the order they were written. The FIFO holds DEPTH bytes, and address 3 reads the current level.
- R4: Control bits [2:1] select the trigger: 0→8, 1→4, 2→2, 3→0 bytes. The low-water flag is set in every cycle that follows a cycle in which the level is at or below the trigger. Once set, it stays set until the host clears it.
- R5: Writing 0 to status bit 0 or bit 1 clears that flag only if the flag was read as 1 since it was last cleared. Otherwise the flag is unchanged. Writing 1 to either bit has no effect.
- R6: The done flag becomes 1 in the cycle right after the final stop bit ends with the FIFO empty. It is 0 whenever the FIFO holds data or a frame is in progress.
- R7: A data write while the FIFO is full is discarded and sets the sticky overflow bit (status bit 2). Writing 0 to bit 2 clears it.
- R8: Clearing control bit 0 (transmit enable) abandons any frame in progress and empties the FIFO. With enable 0 and control bit 3 at 0, tx_o is high.
- R9: With enable 0 and control bit 3 at 1, tx_o follows control bit 4, so a 0 there holds a break. With enable 1, the override has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe; arms flag clearing |
| addr_i | input | 3 | Register address |
| wdata_i | input | BUS_W | Write data |
| rdata_o | output | BUS_W | Read data, combinational on addr_i |
| tx_o | output | 1 | Serial output line |

## Verification
The bench builds the block with a 16-entry FIFO and a divisor of 2, so each bit lasts 3 cycles. This makes it practical to send all 256 byte values through the FIFO and decode every frame from the line. The small depth also allows a full sweep of every level from empty to full against all four trigger settings, and it lets the FIFO reach its full and overflow cases quickly.

// File: rtl/stq_pkg.sv
package stq_pkg;
  localparam logic [2:0] A_DATA  = 3'd0;
  localparam logic [2:0] A_STAT  = 3'd1;
  localparam logic [2:0] A_CTRL  = 3'd2;
  localparam logic [2:0] A_LEVEL = 3'd3;
  localparam logic [2:0] A_DIV   = 3'd4;

  function automatic int unsigned trig_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 4;
      2'd2:    return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/stq_fifo.sv
module stq_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] level;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i)  rd_ptr <= nxt(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign dout_o  = mem[rd_ptr];
  assign level_o = level;
  assign full_o  = (level == LVL_W'(DEPTH));
  assign empty_o = (level == '0);
endmodule

// File: rtl/stq_shifter.sv
module stq_shifter #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             avail_i,
  input  logic [7:0]       data_i,
  output logic             pop_o,
  output logic             line_o,
  output logic             busy_o,
  output logic             end_o
);
  localparam int FRAME_BITS = 10;

  logic [FRAME_BITS-1:0] frame_q;
  logic [3:0]            bit_q;
  logic [DIV_W-1:0]      baud_q;
  logic                  busy_q;
  logic                  tick, last;

  assign tick   = (baud_q == div_i);
  assign last   = (bit_q == 4'(FRAME_BITS - 1));
  assign pop_o  = en_i & ~busy_q & avail_i;
  assign end_o  = en_i & busy_q & tick & last;
  assign line_o = busy_q ? frame_q[0] : 1'b1;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '1;
      bit_q   <= '0;
      baud_q  <= '0;
      busy_q  <= 1'b0;
    end else if (!en_i) begin
      busy_q  <= 1'b0;  // abandon partial frame
      frame_q <= '1;
    end else if (!busy_q) begin
      if (avail_i) begin
        frame_q <= {1'b1, data_i, 1'b0};
        bit_q   <= '0;
        baud_q  <= '0;
        busy_q  <= 1'b1;
      end
    end else if (tick) begin
      baud_q <= '0;
      if (last) begin
        busy_q <= 1'b0;
      end else begin
        frame_q <= {1'b1, frame_q[FRAME_BITS-1:1]};
        bit_q   <= bit_q + 1'b1;
      end
    end else begin
      baud_q <= baud_q + 1'b1;
    end
  end
endmodule

// File: rtl/stq_flag.sv
module stq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  input  logic rd_stat_i,
  input  logic wr_stat_i,
  input  logic wbit_i,
  output logic clr_o
);
  logic armed_q;

  assign clr_o = armed_q & flag_i & wr_stat_i & ~wbit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                armed_q <= 1'b0;
    else if (!flag_i || clr_o)  armed_q <= 1'b0;
    else if (rd_stat_i)         armed_q <= 1'b1;
  end
endmodule

// File: rtl/serial_tx_queue.sv
module serial_tx_queue #(
  parameter int DEPTH   = 64,
  parameter int DIV_W   = 16,
  parameter int DIV_RST = 15,
  parameter int BUS_W   = 16,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [2:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             tx_o
);
  import stq_pkg::*;

  logic             en_q, dir_q, pdat_q;
  logic [1:0]       sel_q;
  logic [DIV_W-1:0] div_q;
  logic             low_q, done_q, ovf_q;
  logic [LVL_W-1:0] level;
  logic             full, empty, pop, busy, end_pulse, line;
  logic [7:0]       fifo_dout;
  logic             wr_data, wr_stat, wr_ctrl, rd_stat, push, flush;
  logic [LVL_W-1:0] trig;
  logic [1:0]       flag_val, clr_hit;

  assign wr_data = wr_i & (addr_i == A_DATA);
  assign wr_stat = wr_i & (addr_i == A_STAT);
  assign wr_ctrl = wr_i & (addr_i == A_CTRL);
  assign rd_stat = rd_i & (addr_i == A_STAT);
  assign push    = wr_data & ~full;
  assign flush   = wr_ctrl & en_q & ~wdata_i[0];
  assign trig    = LVL_W'(trig_bytes(sel_q));

  stq_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i(flush), .push_i(push), .din_i(wdata_i[7:0]),
    .pop_i(pop), .dout_o(fifo_dout),
    .level_o(level), .full_o(full), .empty_o(empty)
  );

  stq_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk_i, .rst_ni,
    .en_i(en_q), .div_i(div_q), .avail_i(~empty), .data_i(fifo_dout),
    .pop_o(pop), .line_o(line), .busy_o(busy), .end_o(end_pulse)
  );

  assign flag_val = {done_q, low_q};

  for (genvar g = 0; g < 2; g++) begin : g_flag
    stq_flag u_flag (
      .clk_i, .rst_ni,
      .flag_i(flag_val[g]), .rd_stat_i(rd_stat), .wr_stat_i(wr_stat),
      .wbit_i(wdata_i[g]), .clr_o(clr_hit[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      dir_q  <= 1'b0;
      pdat_q <= 1'b0;
      div_q  <= DIV_W'(DIV_RST);
    end else begin
      if (wr_ctrl) begin
        en_q   <= wdata_i[0];
        sel_q  <= wdata_i[2:1];
        dir_q  <= wdata_i[3];
        pdat_q <= wdata_i[4];
      end
      if (wr_i && addr_i == A_DIV) div_q <= wdata_i[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q  <= 1'b1;
      done_q <= 1'b1;
      ovf_q  <= 1'b0;
    end else begin
      low_q  <= (level <= trig) | (low_q & ~clr_hit[0]);
      // done only while idle and empty; set by the final stop bit
      done_q <= ~push & empty & (end_pulse | (~busy & done_q & ~clr_hit[1]));
      ovf_q  <= (wr_data & full) | (ovf_q & ~(wr_stat & ~wdata_i[2]));
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_STAT:  rdata_o[2:0] = {ovf_q, done_q, low_q};
      A_CTRL:  rdata_o[4:0] = {pdat_q, dir_q, sel_q, en_q};
      A_LEVEL: rdata_o[LVL_W-1:0] = level;
      A_DIV:   rdata_o[DIV_W-1:0] = div_q;
      default: rdata_o = '0;
    endcase
  end

  assign tx_o = en_q ? line : (dir_q ? pdat_q : 1'b1);
endmodule

// File: rtl/stq_chk.sv
module stq_chk #(
  parameter int DEPTH = 64,
  parameter int LVL_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LVL_W-1:0] level_i,
  input logic             busy_i,
  input logic             done_i,
  input logic             ovf_i,
  input logic             en_i,
  input logic             dir_i,
  input logic             pdat_i,
  input logic             tx_i,
  input logic             wr_data_i,
  input logic             full_i,
  input logic             end_i
);
  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (level_i == '0 && !busy_i));
  // R6
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $past(end_i));
  // R7
  ovf_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_i) |-> $past(wr_data_i && full_i));
  // R3
  level_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i <= LVL_W'(DEPTH));
  // R8
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !dir_i) |-> tx_i);
  // R9
  brk_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && dir_i) |-> (tx_i == pdat_i));
endmodule

bind serial_tx_queue stq_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .level_i(level), .busy_i(busy),
  .done_i(done_q), .ovf_i(ovf_q), .en_i(en_q), .dir_i(dir_q),
  .pdat_i(pdat_q), .tx_i(tx_o), .wr_data_i(wr_data), .full_i(full),
  .end_i(end_pulse)
);

// File: tb/serial_tx_queue_tb.sv
module serial_tx_queue_tb;
  localparam int DEPTH = 16;
  localparam int P     = 3;
  localparam logic [2:0] A_DATA = 0, A_STAT = 1, A_CTRL = 2, A_LEVEL = 3, A_DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = A_STAT;
  logic [15:0] wdata = '0, rdata;
  logic tx;
  int checks = 0, errors = 0;

  bit rx_on = 0;
  int rx_cnt = 0;
  logic [7:0] rb;
  logic st, sp;
  logic [2:0] tr;

  always #4 clk = ~clk;

  serial_tx_queue #(.DEPTH(DEPTH), .DIV_W(16), .DIV_RST(15), .BUS_W(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_o(tx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr = 1'b0; addr = A_STAT;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk); #1;
    rd = 1'b0; addr = A_STAT;
  endtask

  function automatic int trig_of(input int sel);
    case (sel)
      0: return 8;
      1: return 4;
      2: return 2;
      default: return 0;
    endcase
  endfunction

  // line decoder: samples each bit at its centre
  always begin
    @(negedge clk);
    if (rx_on && tx === 1'b0) begin
      @(negedge clk); st = tx;
      for (int i = 0; i < 8; i++) begin
        repeat (P) @(negedge clk);
        rb[i] = tx;
      end
      repeat (P) @(negedge clk); sp = tx; tr[0] = rdata[1];
      @(negedge clk); tr[1] = rdata[1];
      @(negedge clk); tr[2] = rdata[1];
      if (rx_on) begin
        // R2 R3 framing, order
        check(rb == rx_cnt[7:0] && st == 1'b0 && sp == 1'b1, "R2 R3 frame byte",
              int'(rb), rx_cnt & 255);
        // R6 done: 0 at stop centre, 0 in last stop cycle, 1 right after
        if (rx_cnt == 255) check(tr == 3'b100, "R6 done timing", int'(tr), 4);
        rx_cnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(A_STAT, v);  check(v[2:0] == 3'b011, "R1 status", int'(v[2:0]), 3);
    rd_reg(A_LEVEL, v); check(v == 0, "R1 level", int'(v), 0);
    check(tx == 1'b1, "R1 line idle", int'(tx), 1);

    wr_reg(A_DIV, 16'd2);

    // R4 trigger sweep over all selects and levels
    for (int sel = 0; sel < 4; sel++) begin
      for (int lvl = 0; lvl <= DEPTH; lvl++) begin
        wr_reg(A_CTRL, 16'(sel * 2 + 1));
        wr_reg(A_CTRL, 16'(sel * 2));
        for (int k = 0; k < lvl; k++) wr_reg(A_DATA, 16'(k));
        rd_reg(A_STAT, v);
        wr_reg(A_STAT, 16'd0);
        rd_reg(A_STAT, v);
        check(v[0] == (lvl <= trig_of(sel)), "R4 low-water vs trigger",
              int'(v[0]), int'(lvl <= trig_of(sel)));
      end
    end

    // R5 clear without prior read leaves flag set
    wr_reg(A_CTRL, 16'd1);
    wr_reg(A_CTRL, 16'd0);
    for (int k = 0; k < 10; k++) wr_reg(A_DATA, 16'(k));
    wr_reg(A_STAT, 16'd0);
    rd_reg(A_STAT, v);  check(v[0] == 1'b1, "R5 unarmed clear ignored", int'(v[0]), 1);
    wr_reg(A_STAT, 16'd0);
    rd_reg(A_STAT, v);  check(v[0] == 1'b0, "R5 armed clear", int'(v[0]), 0);

    // R7 overflow
    wr_reg(A_CTRL, 16'd1);
    wr_reg(A_CTRL, 16'd0);
    for (int k = 0; k <= DEPTH; k++) wr_reg(A_DATA, 16'(k));
    rd_reg(A_LEVEL, v); check(v == DEPTH, "R7 R3 level at full", int'(v), DEPTH);
    rd_reg(A_STAT, v);  check(v[2] == 1'b1, "R7 overflow set", int'(v[2]), 1);
    wr_reg(A_STAT, 16'd3);
    rd_reg(A_STAT, v);  check(v[2] == 1'b0, "R7 overflow cleared", int'(v[2]), 0);
    rd_reg(A_LEVEL, v); check(v == DEPTH, "R7 full write discarded", int'(v), DEPTH);

    // R2 R3 R6 all byte values through the line
    wr_reg(A_CTRL, 16'd1);
    wr_reg(A_CTRL, 16'd0);
    rx_cnt = 0;
    rx_on = 1;
    wr_reg(A_CTRL, 16'd1);
    for (int c = 0; c < 256 / DEPTH; c++) begin
      for (int j = 0; j < DEPTH; j++) wr_reg(A_DATA, 16'(c * DEPTH + j));
      while (rx_cnt < (c + 1) * DEPTH) @(negedge clk);
    end
    rx_on = 0;
    repeat (4) @(negedge clk);

    // R5 done flag clear protocol, writing 1 has no effect
    rd_reg(A_STAT, v);  check(v[1] == 1'b1, "R6 done after drain", int'(v[1]), 1);
    wr_reg(A_STAT, 16'd2);
    rd_reg(A_STAT, v);  check(v[1] == 1'b1, "R5 write one ignored", int'(v[1]), 1);
    wr_reg(A_STAT, 16'd0);
    rd_reg(A_STAT, v);  check(v[1] == 1'b0, "R5 done cleared", int'(v[1]), 0);

    // R4 flag rises as the level drains to trigger 4
    wr_reg(A_CTRL, 16'd2);
    for (int k = 0; k < DEPTH; k++) wr_reg(A_DATA, 16'(k));
    rd_reg(A_STAT, v);
    wr_reg(A_STAT, 16'd0);
    rd_reg(A_STAT, v);  check(v[0] == 1'b0, "R4 flag cleared above trigger", int'(v[0]), 0);
    rd_reg(A_STAT, v);  check(v[1] == 1'b0, "R6 done clear while queued", int'(v[1]), 0);
    wr_reg(A_CTRL, 16'd3);
    do rd_reg(A_LEVEL, v); while (v != 5);
    rd_reg(A_STAT, v);  check(v[0] == 1'b0, "R4 level 5 above trigger", int'(v[0]), 0);
    do rd_reg(A_LEVEL, v); while (v != 4);
    rd_reg(A_STAT, v);  check(v[0] == 1'b1, "R4 level 4 at trigger", int'(v[0]), 1);

    // R8 disable flushes and abandons
    repeat (12) @(negedge clk);
    wr_reg(A_CTRL, 16'd2);
    rd_reg(A_LEVEL, v); check(v == 0, "R8 flush on disable", int'(v), 0);
    ok = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (tx !== 1'b1) ok = 0;
    end
    check(ok, "R8 line high while disabled", int'(ok), 1);
    wr_reg(A_CTRL, 16'd3);
    ok = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (tx !== 1'b1) ok = 0;
    end
    check(ok, "R8 abandoned byte not resent", int'(ok), 1);

    // R9 break override
    wr_reg(A_CTRL, 16'd8);  #1 check(tx == 1'b0, "R9 break low", int'(tx), 0);
    wr_reg(A_CTRL, 16'd24); #1 check(tx == 1'b1, "R9 override high", int'(tx), 1);
    wr_reg(A_CTRL, 16'd9);  #1 check(tx == 1'b1, "R9 ignored when enabled", int'(tx), 1);
    wr_reg(A_CTRL, 16'd8);  #1 check(tx == 1'b0, "R9 break after disable", int'(tx), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule